// File: doc/BRIEF.md
# Four-Level Address Strap Decoder

This block works out how two address-strap pins are wired on the board. Each pin can be tied to ground, to the supply, to the serial clock line or to the serial data line. The block does not sense the pins electrically. It takes synchronized samples of the two bus lines and the two strap pins. It then compares each strap against the bus lines while a bus transfer is in progress. A strap that follows one of the lines is classed as that line. A strap that holds one level for the whole transfer is classed as ground or as supply.

From the two classes the block produces three outputs:
- the four low bits of the slave address;
- one pullup-enable bit for each four-input group;
- the power-up default level for each group of output ports.

Every START/STOP window on the bus is examined, whichever device it addresses, so a strap that is rewired takes effect without a power cycle. The new classes are committed only at STOP. The decoded values therefore never change in the middle of a transfer.

Before the first complete transfer, both straps are treated as tied to supply.

Top module: `strap_decoder`

## Requirements
- R1: After reset both straps are classed as supply: `addr_lo` = 4'b1101, `pullup_en` = 2'b11, `out_default` all ones.
- R2: At each STOP that ends a START..STOP window, each strap is classed as follows:
  - supply, if it was never low in the window;
  - ground, if it was never high;
  - SCL, if it equalled SCL at every sample where SCL and SDA differed;
  - SDA, if it equalled SDA at every such sample.
  The START and STOP samples belong to the window.
- R3: `addr_lo[1:0]` encodes strap 0: ground 00, supply 01, SCL 10, SDA 11.
- R4: `addr_lo[3:2]` encodes strap 1: SCL 00, SDA 01, ground 10, supply 11.
- R5: `pullup_en[0]` follows strap 0 and `pullup_en[1]` follows strap 1. Each bit is 0 for ground and 1 for any other class.
- R6: `out_default[GROUP_W-1:0]` is all zeros when strap 0 is ground and all ones otherwise. The upper group follows strap 1 in the same way.
- R7: Outputs change only in the cycle after a STOP is sampled. They hold their values through a whole transfer.
- R8: Every window is decoded anew, so a strap wired differently in a later transfer changes the outputs after that transfer's STOP.
- R9: With KEEP_ON_AMBIG = 1 (the default), a strap that toggles but matches neither line keeps its previous class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_s | input | 1 | Synchronized sample of the serial clock line |
| sda_s | input | 1 | Synchronized sample of the serial data line |
| strap0_s | input | 1 | Synchronized sample of strap 0 (low address bits, inputs 0-3) |
| strap1_s | input | 1 | Synchronized sample of strap 1 (high address bits, inputs 4-7) |
| addr_lo | output | 4 | Low four slave-address bits |
| pullup_en | output | 2 | Pullup enable per input group |
| out_default | output | 2*GROUP_W | Power-up default levels for the two output groups |

## Verification
A misclassified strap becomes visible at `addr_lo`, `pullup_en` and `out_default` one cycle after the STOP of the window that caused it. The bench checks all three after every transfer, so such an error is caught at once.

An observation history that leaks from one window into the next shows up as a wrong class after the following transfer. An early commit shows up as output movement in the middle of a transfer, which the bench checks between bytes.

A wrong fallback for an ambiguous strap shows up as the strap losing the class it held before.

// File: rtl/strap_pkg.sv
package strap_pkg;

   typedef enum logic [1:0] {
      STRAP_GND = 2'd0,
      STRAP_VCC = 2'd1,
      STRAP_SCL = 2'd2,
      STRAP_SDA = 2'd3
   } strap_e;

   typedef struct packed {
      logic seen_hi;
      logic seen_lo;
      logic seen_diff;
      logic miss_scl;
      logic miss_sda;
   } strap_obs_t;

   // Low address pair driven by strap 0
   function automatic logic [1:0] low_pair_code(input strap_e c);
      case (c)
         STRAP_GND: low_pair_code = 2'b00;
         STRAP_VCC: low_pair_code = 2'b01;
         STRAP_SCL: low_pair_code = 2'b10;
         default:   low_pair_code = 2'b11;
      endcase
   endfunction

   // High address pair driven by strap 1
   function automatic logic [1:0] high_pair_code(input strap_e c);
      case (c)
         STRAP_SCL: high_pair_code = 2'b00;
         STRAP_SDA: high_pair_code = 2'b01;
         STRAP_GND: high_pair_code = 2'b10;
         default:   high_pair_code = 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/strap_bus_frame.sv
module strap_bus_frame (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic frame_start,
   output logic sample_en,
   output logic commit
);
   logic scl_q, sda_q, in_frame_q;
   logic start_det, stop_det;

   assign start_det = scl_q & scl_s & sda_q & ~sda_s;
   assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q      <= 1'b1;
         sda_q      <= 1'b1;
         in_frame_q <= 1'b0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         if (start_det)     in_frame_q <= 1'b1;
         else if (stop_det) in_frame_q <= 1'b0;
      end
   end

   assign frame_start = start_det;
   assign sample_en   = start_det | in_frame_q;
   assign commit      = stop_det & in_frame_q;
endmodule

// File: rtl/strap_observer.sv
module strap_observer
   import strap_pkg::*;
#(
   parameter bit KEEP_ON_AMBIG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   scl_s,
   input  logic   sda_s,
   input  logic   pin_s,
   input  logic   frame_start,
   input  logic   sample_en,
   input  logic   commit,
   output strap_e cls_o
);
   strap_obs_t obs_q, obs_now, obs_acc;
   strap_e     cls_q, ambig_cls, verdict;
   logic       lines_differ;

   assign lines_differ = scl_s ^ sda_s;

   always_comb begin
      obs_now.seen_hi   = pin_s;
      obs_now.seen_lo   = ~pin_s;
      obs_now.seen_diff = lines_differ;
      obs_now.miss_scl  = lines_differ & (pin_s ^ scl_s);
      obs_now.miss_sda  = lines_differ & (pin_s ^ sda_s);
      obs_acc = frame_start ? obs_now : (obs_q | obs_now);
   end

   generate
      if (KEEP_ON_AMBIG) begin : g_keep
         assign ambig_cls = cls_q;
      end else begin : g_high
         assign ambig_cls = STRAP_VCC;
      end
   endgenerate

   always_comb begin
      if (!obs_acc.seen_lo)                          verdict = STRAP_VCC;
      else if (!obs_acc.seen_hi)                     verdict = STRAP_GND;
      else if (obs_acc.seen_diff && !obs_acc.miss_scl) verdict = STRAP_SCL;
      else if (obs_acc.seen_diff && !obs_acc.miss_sda) verdict = STRAP_SDA;
      else                                           verdict = ambig_cls;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obs_q <= '0;
         cls_q <= STRAP_VCC;
      end else begin
         if (sample_en) obs_q <= obs_acc;
         if (commit)    cls_q <= verdict;
      end
   end

   assign cls_o = cls_q;
endmodule

// File: rtl/strap_map.sv
module strap_map
   import strap_pkg::*;
#(
   parameter int GROUP_W = 4
) (
   input  strap_e               cls0,
   input  strap_e               cls1,
   output logic [3:0]           addr_lo,
   output logic [1:0]           pullup_en,
   output logic [2*GROUP_W-1:0] out_default
);
   strap_e cls_arr [2];

   assign cls_arr[0] = cls0;
   assign cls_arr[1] = cls1;
   assign addr_lo    = {high_pair_code(cls1), low_pair_code(cls0)};

   for (genvar g = 0; g < 2; g++) begin : g_grp
      assign pullup_en[g] = (cls_arr[g] != STRAP_GND);
      assign out_default[g*GROUP_W +: GROUP_W] =
         {GROUP_W{cls_arr[g] != STRAP_GND}};
   end
endmodule

// File: rtl/strap_decoder.sv
module strap_decoder
   import strap_pkg::*;
#(
   parameter int GROUP_W       = 4,
   parameter bit KEEP_ON_AMBIG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_s,
   input  logic                 sda_s,
   input  logic                 strap0_s,
   input  logic                 strap1_s,
   output logic [3:0]           addr_lo,
   output logic [1:0]           pullup_en,
   output logic [2*GROUP_W-1:0] out_default
);
   localparam int NUM_STRAPS = 2;

   if (GROUP_W < 1 || GROUP_W > 16) begin : g_bad_width
      $error("strap_decoder: GROUP_W must be 1..16");
   end

   logic   frame_start, sample_en, commit;
   logic   pins [NUM_STRAPS];
   strap_e cls  [NUM_STRAPS];

   assign pins[0] = strap0_s;
   assign pins[1] = strap1_s;

   strap_bus_frame u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_s       (scl_s),
      .sda_s       (sda_s),
      .frame_start (frame_start),
      .sample_en   (sample_en),
      .commit      (commit)
   );

   for (genvar p = 0; p < NUM_STRAPS; p++) begin : g_obs
      strap_observer #(.KEEP_ON_AMBIG(KEEP_ON_AMBIG)) u_obs (
         .clk         (clk),
         .rst_n       (rst_n),
         .scl_s       (scl_s),
         .sda_s       (sda_s),
         .pin_s       (pins[p]),
         .frame_start (frame_start),
         .sample_en   (sample_en),
         .commit      (commit),
         .cls_o       (cls[p])
      );
   end

   strap_map #(.GROUP_W(GROUP_W)) u_map (
      .cls0        (cls[0]),
      .cls1        (cls[1]),
      .addr_lo     (addr_lo),
      .pullup_en   (pullup_en),
      .out_default (out_default)
   );
endmodule

// File: rtl/strap_decoder_chk.sv
module strap_decoder_chk #(
   parameter int GROUP_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scl_s,
   input logic                 sda_s,
   input logic [3:0]           addr_lo,
   input logic [1:0]           pullup_en,
   input logic [2*GROUP_W-1:0] out_default
);
   // R1: values seen at the first clock out of reset
   a_r1_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (addr_lo == 4'b1101 && pullup_en == 2'b11 && out_default == '1));

   // R7: no STOP sampled means no output movement in the following cycle
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_s && sda_s && $past(scl_s) && !$past(sda_s)) |=> $stable(addr_lo));

   a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_s && sda_s && $past(scl_s) && !$past(sda_s))
         |=> ($stable(pullup_en) && $stable(out_default)));

   // R6: each default group is uniform and agrees with its pullup bit (R5)
   a_r6_group0_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      out_default[GROUP_W-1:0] == {GROUP_W{pullup_en[0]}});

   a_r6_group1_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      out_default[2*GROUP_W-1:GROUP_W] == {GROUP_W{pullup_en[1]}});

   // R3: a grounded strap 0 gives code 00
   a_r3_ground_code: assert property (@(posedge clk) disable iff (!rst_n)
      !pullup_en[0] |-> addr_lo[1:0] == 2'b00);

   // R4: a grounded strap 1 gives code 10
   a_r4_ground_code: assert property (@(posedge clk) disable iff (!rst_n)
      !pullup_en[1] |-> addr_lo[3:2] == 2'b10);
endmodule

bind strap_decoder strap_decoder_chk #(.GROUP_W(GROUP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .sda_s       (sda_s),
   .addr_lo     (addr_lo),
   .pullup_en   (pullup_en),
   .out_default (out_default)
);

// File: tb/strap_decoder_test.sv
module strap_decoder_test;
   localparam int GROUP_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic phase = 1'b0;
   int   mode0 = 1;
   int   mode1 = 1;
   logic pin0, pin1;
   logic [3:0]           addr_lo;
   logic [1:0]           pullup_en;
   logic [2*GROUP_W-1:0] out_default;

   int   checks = 0;
   int   failures = 0;
   bit   done = 0;
   int   cur0 = 1;
   int   cur1 = 1;

   always #4 clk = ~clk;

   // mode: 0 ground, 1 supply, 2 SCL, 3 SDA, 4 ambiguous (SDA then SCL)
   assign pin0 = (mode0 == 0) ? 1'b0 : (mode0 == 1) ? 1'b1 : (mode0 == 2) ? scl :
                 (mode0 == 3) ? sda : (phase ? scl : sda);
   assign pin1 = (mode1 == 0) ? 1'b0 : (mode1 == 1) ? 1'b1 : (mode1 == 2) ? scl :
                 (mode1 == 3) ? sda : (phase ? scl : sda);

   strap_decoder #(.GROUP_W(GROUP_W)) uut (
      .clk(clk), .rst_n(rst_n), .scl_s(scl), .sda_s(sda),
      .strap0_s(pin0), .strap1_s(pin1),
      .addr_lo(addr_lo), .pullup_en(pullup_en), .out_default(out_default)
   );

   function automatic logic [1:0] exp_low(input int c);
      case (c)
         0: exp_low = 2'b00;
         1: exp_low = 2'b01;
         2: exp_low = 2'b10;
         default: exp_low = 2'b11;
      endcase
   endfunction

   function automatic logic [1:0] exp_high(input int c);
      case (c)
         2: exp_high = 2'b00;
         3: exp_high = 2'b01;
         0: exp_high = 2'b10;
         default: exp_high = 2'b11;
      endcase
   endfunction

   function automatic logic [2*GROUP_W-1:0] exp_def(input int c0, input int c1);
      exp_def = {{GROUP_W{c1 != 0}}, {GROUP_W{c0 != 0}}};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R3 addr low pair"}, 32'(addr_lo[1:0]), 32'(exp_low(cur0)));
      chk({tag, " R4 addr high pair"}, 32'(addr_lo[3:2]), 32'(exp_high(cur1)));
      chk({tag, " R5 pullups"}, 32'(pullup_en), 32'({cur1 != 0, cur0 != 0}));
      chk({tag, " R6 defaults"}, 32'(out_default), 32'(exp_def(cur0, cur1)));
   endtask

   task automatic half();
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sda = b; half();
      scl = 1'b1; half();
      scl = 1'b0; half();
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      send_bit(1'($urandom_range(0, 1)));
   endtask

   // One START..STOP transfer; second and later bytes are in phase 1
   task automatic transfer(input int nbytes, input logic [7:0] second);
      logic [3:0] a_before;
      a_before = addr_lo;
      phase = 1'b0;
      scl = 1'b1; sda = 1'b1; half();
      sda = 1'b0; half();
      scl = 1'b0; half();
      send_byte(8'h80 | 8'($urandom_range(0, 255)));
      chk("R7 mid-transfer hold", 32'(addr_lo), 32'(a_before));
      phase = 1'b1;
      for (int b = 1; b < nbytes; b++) send_byte(b == 1 ? second : 8'($urandom_range(0, 255)));
      sda = 1'b0; half();
      scl = 1'b1; half();
      chk("R7 hold before STOP", 32'(addr_lo), 32'(a_before));
      sda = 1'b1; half();
      phase = 1'b0;
   endtask

   task automatic apply(input int m0, input int m1, input int nbytes, input logic [7:0] second);
      mode0 = m0; mode1 = m1;
      transfer(nbytes, second);
      if (m0 < 4) cur0 = m0;
      if (m1 < 4) cur1 = m1;
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 addr", 32'(addr_lo), 32'h0000_000d);
      chk("R1 pullups", 32'(pullup_en), 32'h3);
      chk("R1 defaults", 32'(out_default), 32'({2*GROUP_W{1'b1}}));

      // R2 directed: every class on each strap
      apply(0, 2, 2, 8'h5a); check_all("R2 gnd/scl");
      apply(3, 0, 2, 8'h33); check_all("R2 sda/gnd");
      apply(2, 3, 1, 8'h00); check_all("R2 scl/sda");
      apply(1, 1, 3, 8'hc3); check_all("R2 vcc/vcc");

      // R9 ambiguous strap keeps previous class
      apply(3, 2, 2, 8'h00); check_all("R9 setup");
      apply(4, 4, 2, 8'h00); check_all("R9 ambiguous keep");

      // R8 random rewiring across many transfers
      for (int t = 0; t < 40; t++) begin
         apply($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(1, 3),
               8'($urandom_range(0, 255)));
         check_all("R8 random");
      end

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule